// File: doc/BRIEF.md
# Load/Store Byte-Lane Steering Unit

This block sits between a 32-bit register file and a 32-bit memory data bus and moves byte, halfword and word values between the two. On the store side it turns a register value, an access size and the low address bits into a set of per-lane write enables and a bus word that carries the value on the lanes being written. On the load side it takes the word read from memory, picks out the addressed byte or halfword, zero-extends it and returns it one cycle later with a completion pulse.

A static mode input chooses the byte ordering. In little-endian mode the byte at the lowest address carries the least significant bits of a word. In big-endian mode it carries the most significant bits. Either way, the value 0x12345678 keeps that same value when it is stored or loaded as a whole word. Only the position of the sub-word pieces changes. Accesses whose address is not a multiple of their size are flagged, and a flagged store writes nothing.

Bus lane i is bits [8i+7:8i]. The access size is encoded as 0 = byte, 1 = halfword, 2 = word and 3 = reserved. The byte offset is the address modulo 4.

Top module: `lane_steer`

## Requirements
- R1: `align_err` is high in a cycle where `st_req` or `rd_valid` is high and the access is invalid, and it is low in every other cycle. An access is invalid when it is a halfword at an odd offset, a word at a nonzero offset, or it uses size code 3. A byte access is never invalid.
- R2: An invalid store drives `mem_be` to all zeros in that cycle.
- R3: Little-endian store enables: a byte at offset k enables lane k only. A halfword at offset 0 enables lanes 0 and 1 (`mem_be`=4'b0011). A halfword at offset 2 enables lanes 2 and 3 (4'b1100). A word enables all four lanes.
- R4: Big-endian store enables: a byte at offset k enables lane 3-k only. A halfword at offset 0 enables 4'b1100, and a halfword at offset 2 enables 4'b0011. A word enables all four lanes.
- R5: Store data is replicated and does not depend on the byte order. A byte store drives four copies of `st_src[7:0]` and a halfword store drives two copies of `st_src[15:0]`. A word store drives `st_src` unchanged. When `st_req` is low, `mem_be` is zero.
- R6: A little-endian byte load at offset k returns bus lane k in bits [7:0] with bits [31:8] zero. A halfword load at offset h returns lanes h and h+1, with lane h as the low byte, in bits [15:0] and with bits [31:16] zero.
- R7: A big-endian byte load at offset k returns lane 3-k, zero-extended. A halfword load at offset 0 returns bus bits [31:16], and at offset 2 it returns bits [15:0], each zero-extended.
- R8: A word load returns the bus word unchanged in either byte order.
- R9: `ld_done` is high in exactly the cycle after each cycle with `rd_valid` high, and `ld_data` is valid in that cycle. `ld_data` keeps its value while `rd_valid` is low.
- R10: An invalid load still produces its `ld_done` pulse, and it returns `ld_data` = 0.
- R11: After reset, `ld_done` and `ld_data` are zero, and with no request `mem_be` and `align_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Static byte order: 1 = big-endian, 0 = little-endian |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| acc_off | input | 2 | Byte offset of the access within the word |
| st_req | input | 1 | Store request this cycle |
| st_src | input | 32 | Register value to be stored |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Steered store data |
| rd_valid | input | 1 | Read data on `mem_rdata` is valid this cycle |
| mem_rdata | input | 32 | Word read from memory |
| ld_data | output | 32 | Zero-extended load result |
| ld_done | output | 1 | One-cycle pulse when `ld_data` is updated |
| align_err | output | 1 | Invalid access flag |

## Verification
The bench walks every offset under each size in both byte orders, using the example word 0x12345678. That sweep exposes an unit that mirrors lanes the wrong way round: it would return 0x78 instead of 0x12 for a big-endian byte at offset 0. It would also expose one that leaves stale upper bits in a byte or halfword result. Misaligned halfwords, nonzero-offset words and the reserved size are driven as stores and as loads. A design that let such a store through would show nonzero enables, and one that dropped the completion pulse of a bad load would stall its requester. The load timing test checks that the result arrives exactly one cycle after the strobe, that the pulse is a single cycle long, and that the result then holds.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_RSVD = 2'd3;

  // number of bytes moved by an access of the given size code
  function automatic int unsigned size_bytes(logic [1:0] sz);
    return 32'd1 << sz;
  endfunction

  // an access is bad when the size code is reserved, when it is wider than the bus,
  // or when its offset is not a multiple of its size
  function automatic logic bad_access(logic [1:0] sz, int unsigned off, int unsigned lanes);
    int unsigned nb;
    nb = size_bytes(sz);
    if (sz == SZ_RSVD) return 1'b1;
    if (nb > lanes) return 1'b1;
    return (off & (nb - 1)) != 0;
  endfunction

  // lowest bus lane used by an aligned access; the least significant byte of the
  // value always lands on that lane, in both byte orders
  function automatic int unsigned low_lane(logic big, logic [1:0] sz, int unsigned off,
                                           int unsigned lanes);
    int unsigned nb;
    nb = size_bytes(sz);
    if (bad_access(sz, off, lanes)) return 0;
    return big ? (lanes - off - nb) : off;
  endfunction

endpackage

// File: rtl/lane_align_chk.sv
module lane_align_chk #(
  parameter int unsigned LANES = 4,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic [1:0]       acc_size,
  input  logic [OFF_W-1:0] acc_off,
  output logic             bad
);
  import lane_steer_pkg::*;

  always_comb begin
    bad = bad_access(acc_size, 32'(acc_off), LANES);
  end
endmodule

// File: rtl/lane_store_pack.sv
module lane_store_pack #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic              enable,
  input  logic              big_endian,
  input  logic [1:0]        acc_size,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);
  import lane_steer_pkg::*;

  int unsigned nb;
  int unsigned base;

  always_comb begin
    nb   = size_bytes(acc_size);
    base = low_lane(big_endian, acc_size, 32'(acc_off), LANES);
  end

  // enables: a contiguous run of nb lanes starting at base
  always_comb begin
    for (int unsigned i = 0; i < LANES; i++) begin
      be[i] = enable && (i >= base) && (i < base + nb);
    end
  end

  // data: lane i carries source byte (i mod nb); since base is a multiple of nb
  // this puts byte j of the value on lane base+j without a shifter
  always_comb begin
    logic [OFF_W-1:0] idx;
    for (int unsigned i = 0; i < LANES; i++) begin
      idx = OFF_W'(i & (nb - 1));
      wdata[8*i +: 8] = src[8*idx +: 8];
    end
  end
endmodule

// File: rtl/lane_load_unpack.sv
module lane_load_unpack #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              bad,
  input  logic              big_endian,
  input  logic [1:0]        acc_size,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_done
);
  import lane_steer_pkg::*;

  int unsigned       nb;
  int unsigned       base;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] picked;

  always_comb begin
    nb      = size_bytes(acc_size);
    base    = low_lane(big_endian, acc_size, 32'(acc_off), LANES);
    shifted = rdata >> (8 * base);
    for (int unsigned i = 0; i < LANES; i++) begin
      picked[8*i +: 8] = (!bad && i < nb) ? shifted[8*i +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_data <= '0;
      ld_done <= 1'b0;
    end else begin
      ld_done <= rd_valid;
      if (rd_valid) ld_data <= picked;
    end
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic [1:0]        acc_size,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic              st_req,
  input  logic [DATA_W-1:0] st_src,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_done,
  output logic              align_err
);

  // named internal events
  logic bad_access_w;
  logic store_fire;

  lane_align_chk #(.LANES(LANES)) u_align (
    .acc_size (acc_size),
    .acc_off  (acc_off),
    .bad      (bad_access_w)
  );

  assign store_fire = st_req & ~bad_access_w;
  assign align_err  = (st_req | rd_valid) & bad_access_w;

  lane_store_pack #(.DATA_W(DATA_W)) u_store (
    .enable     (store_fire),
    .big_endian (big_endian),
    .acc_size   (acc_size),
    .acc_off    (acc_off),
    .src        (st_src),
    .be         (mem_be),
    .wdata      (mem_wdata)
  );

  lane_load_unpack #(.DATA_W(DATA_W)) u_load (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid   (rd_valid),
    .bad        (bad_access_w),
    .big_endian (big_endian),
    .acc_size   (acc_size),
    .acc_off    (acc_off),
    .rdata      (mem_rdata),
    .ld_data    (ld_data),
    .ld_done    (ld_done)
  );
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_req,
  input logic              rd_valid,
  input logic [1:0]        acc_size,
  input logic [LANES-1:0]  mem_be,
  input logic              align_err,
  input logic [DATA_W-1:0] ld_data,
  input logic              ld_done
);

  assert_bad_store_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && align_err) |-> (mem_be == '0));

  assert_lane_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !align_err) |-> ($countones(mem_be) == (1 << acc_size)));

  assert_idle_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !st_req |-> (mem_be == '0));

  assert_byte_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !align_err && acc_size == 2'd0) |=> (ld_data[DATA_W-1:8] == '0));

  assert_done_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> ld_done);

  assert_no_spurious_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !ld_done);

  assert_result_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(ld_data));

  assert_bad_load_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && align_err) |=> (ld_data == '0));

endmodule

bind lane_steer lane_steer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_req    (st_req),
  .rd_valid  (rd_valid),
  .acc_size  (acc_size),
  .mem_be    (mem_be),
  .align_err (align_err),
  .ld_data   (ld_data),
  .ld_done   (ld_done)
);

// File: tb/lane_steer_test.sv
`timescale 1ns/1ps
module lane_steer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian = 1'b0;
  logic [1:0]  acc_size = 2'd0;
  logic [1:0]  acc_off = 2'd0;
  logic        st_req = 1'b0;
  logic [31:0] st_src = '0;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        rd_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] ld_data;
  logic        ld_done;
  logic        align_err;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lane_steer uut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .acc_size(acc_size),
    .acc_off(acc_off), .st_req(st_req), .st_src(st_src), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .rd_valid(rd_valid), .mem_rdata(mem_rdata),
    .ld_data(ld_data), .ld_done(ld_done), .align_err(align_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected store enables, written as tables
  function automatic logic [3:0] exp_be(logic big, logic [1:0] sz, logic [1:0] off);
    case (sz)
      2'd0: return big ? (4'b1000 >> off) : (4'b0001 << off);
      2'd1: begin
        if (off == 2'd0) return big ? 4'b1100 : 4'b0011;
        if (off == 2'd2) return big ? 4'b0011 : 4'b1100;
        return 4'b0000;
      end
      2'd2: return (off == 2'd0) ? 4'b1111 : 4'b0000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic exp_bad(logic [1:0] sz, logic [1:0] off);
    return (sz == 2'd3) || (sz == 2'd1 && off[0]) || (sz == 2'd2 && off != 2'd0);
  endfunction

  function automatic logic [31:0] exp_wdata(logic [1:0] sz, logic [31:0] s);
    case (sz)
      2'd0: return {s[7:0], s[7:0], s[7:0], s[7:0]};
      2'd1: return {s[15:0], s[15:0]};
      default: return s;
    endcase
  endfunction

  function automatic logic [31:0] exp_load(logic big, logic [1:0] sz, logic [1:0] off,
                                           logic [31:0] w);
    if (exp_bad(sz, off)) return 32'h0;
    case (sz)
      2'd0: return {24'h0, big ? w[8*(3-off) +: 8] : w[8*off +: 8]};
      2'd1: begin
        if (big) return (off == 2'd0) ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
        return (off == 2'd0) ? {16'h0, w[15:0]} : {16'h0, w[31:16]};
      end
      default: return w;
    endcase
  endfunction

  task automatic do_store(input string tag, input logic big, input logic [1:0] sz,
                          input logic [1:0] off, input logic [31:0] s);
    @(negedge clk);
    big_endian = big; acc_size = sz; acc_off = off; st_src = s; st_req = 1'b1;
    #1;
    chk({tag, " be"}, {28'h0, mem_be}, {28'h0, exp_be(big, sz, off)});
    chk({tag, " err R1"}, {31'h0, align_err}, {31'h0, exp_bad(sz, off)});
    if (!exp_bad(sz, off)) chk({tag, " wdata R5"}, mem_wdata, exp_wdata(sz, s));
    @(negedge clk);
    st_req = 1'b0;
  endtask

  task automatic do_load(input string tag, input logic big, input logic [1:0] sz,
                         input logic [1:0] off, input logic [31:0] w);
    @(negedge clk);
    big_endian = big; acc_size = sz; acc_off = off; mem_rdata = w; rd_valid = 1'b1;
    #1;
    chk({tag, " err R1"}, {31'h0, align_err}, {31'h0, exp_bad(sz, off)});
    @(negedge clk);
    rd_valid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
    #1;
    chk({tag, " done R9"}, {31'h0, ld_done}, 32'h1);
    chk({tag, " data"}, ld_data, exp_load(big, sz, off, w));
  endtask

  task automatic t_reset();
    #1;
    chk("R11 ld_done", {31'h0, ld_done}, 32'h0);
    chk("R11 ld_data", ld_data, 32'h0);
    chk("R11 mem_be", {28'h0, mem_be}, 32'h0);
    chk("R11 align_err", {31'h0, align_err}, 32'h0);
  endtask

  task automatic t_store_little();
    for (int o = 0; o < 4; o++) do_store("R3 le byte", 1'b0, 2'd0, 2'(o), 32'hA1B2C3D4);
    do_store("R3 le half0", 1'b0, 2'd1, 2'd0, 32'h1234_5678);
    do_store("R3 le half2", 1'b0, 2'd1, 2'd2, 32'h1234_5678);
    do_store("R3 le word", 1'b0, 2'd2, 2'd0, 32'h1234_5678);
  endtask

  task automatic t_store_big();
    for (int o = 0; o < 4; o++) do_store("R4 be byte", 1'b1, 2'd0, 2'(o), 32'h0000_005A);
    do_store("R4 be half0", 1'b1, 2'd1, 2'd0, 32'hFFFF_BEEF);
    do_store("R4 be half2", 1'b1, 2'd1, 2'd2, 32'hFFFF_BEEF);
    do_store("R4 be word", 1'b1, 2'd2, 2'd0, 32'h1234_5678);
  endtask

  task automatic t_store_bad();
    do_store("R2 half1", 1'b0, 2'd1, 2'd1, 32'h1111_2222);
    do_store("R2 half3", 1'b1, 2'd1, 2'd3, 32'h1111_2222);
    do_store("R2 word2", 1'b0, 2'd2, 2'd2, 32'h1111_2222);
    do_store("R2 rsvd", 1'b1, 2'd3, 2'd0, 32'h1111_2222);
    @(negedge clk);
    acc_size = 2'd1; acc_off = 2'd1; #1;
    chk("R1 idle no err", {31'h0, align_err}, 32'h0);
    chk("R5 idle be", {28'h0, mem_be}, 32'h0);
  endtask

  task automatic t_load_little();
    for (int o = 0; o < 4; o++) do_load("R6 le byte", 1'b0, 2'd0, 2'(o), 32'h1234_5678);
    do_load("R6 le half0", 1'b0, 2'd1, 2'd0, 32'h8765_4321);
    do_load("R6 le half2", 1'b0, 2'd1, 2'd2, 32'h8765_4321);
    do_load("R8 le word", 1'b0, 2'd2, 2'd0, 32'h1234_5678);
  endtask

  task automatic t_load_big();
    // example word: big-endian offset 0 holds 0x12, offset 3 holds 0x78
    for (int o = 0; o < 4; o++) do_load("R7 be byte", 1'b1, 2'd0, 2'(o), 32'h1234_5678);
    do_load("R7 be half0", 1'b1, 2'd1, 2'd0, 32'h8765_4321);
    do_load("R7 be half2", 1'b1, 2'd1, 2'd2, 32'h8765_4321);
    do_load("R8 be word", 1'b1, 2'd2, 2'd0, 32'h1234_5678);
  endtask

  task automatic t_load_timing();
    logic [31:0] held;
    do_load("R9 first", 1'b0, 2'd0, 2'd1, 32'h00FF_EE00);
    held = ld_data;
    chk("R9 value", held, 32'h0000_00EE);
    @(negedge clk); #1;
    chk("R9 pulse ends", {31'h0, ld_done}, 32'h0);
    chk("R9 holds", ld_data, held);
    @(negedge clk); #1;
    chk("R9 still holds", ld_data, held);
  endtask

  task automatic t_load_bad();
    do_load("R9 prime", 1'b0, 2'd2, 2'd0, 32'hCAFE_F00D);
    do_load("R10 half odd", 1'b0, 2'd1, 2'd3, 32'hCAFE_F00D);
    do_load("R9 prime2", 1'b1, 2'd2, 2'd0, 32'hCAFE_F00D);
    do_load("R10 word off1", 1'b1, 2'd2, 2'd1, 32'hCAFE_F00D);
    do_load("R10 rsvd", 1'b1, 2'd3, 2'd0, 32'hCAFE_F00D);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    #12 rst_n = 1'b1;
    t_reset();
    t_store_little();
    t_store_big();
    t_store_bad();
    t_load_little();
    t_load_big();
    t_load_timing();
    t_load_bad();
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule